// File: doc/BRIEF.md
# Dual-Output Line Delay Memory

This block delays a raster stream of bytes by one line and by two lines at the same time. Bytes enter on a write clock and are stored in a first line buffer at a write address that advances with each accepted byte. On the read clock, every enabled read fetches the byte at the current read address of the first buffer and presents it as the one-line output. The same byte is then copied into a second line buffer, whose earlier content at that address is presented as the two-line output. Both outputs change on the same read-clock edge.

Typical use is a vertical filter over three adjacent lines. The writer and the reader each pulse their own reset at the start of every line, so all address counters stay aligned to the line start. A read at a given address always returns the byte written at that address in an earlier, completed write cycle. When the read edge comes before the write edge at the same address, the read therefore sees the previous line. An output enable forces both data outputs to zero and drops an enable indicator. It has no effect on the stored state.

Top module: `line_delay_mem`

## Requirements
- R1: When `we_ni` is low and `wres_ni` is high at a rising `wclk_i` edge, `wdata_i` is stored at the write address, and the write address then increments.
- R2: When `we_ni` is high, nothing is stored and the write address holds. With `re_ni` also high, the read counters and both outputs hold.
- R3: `wres_ni` low at a rising `wclk_i` edge sets the write address to zero, and no byte is stored on that edge.
- R4: `rres_ni` low at a rising `rclk_i` edge sets both read address counters to zero. No read happens on that edge, and both outputs keep their values.
- R5: An enabled read loads `q1_o` on the read edge with the first-buffer byte at the current read address, so that `q1_o` carries pixel x of line n-1 while line n is being written. Latency is one read cycle.
- R6: On the same edge, `q2_o` is loaded with the second-buffer byte at the current address. The second buffer is filled with the bytes previously read from the first buffer, so `q2_o` carries pixel x of line n-2.
- R7: While `re_ni` is high, the read counters and both data outputs keep their values.
- R8: While `oe_ni` is high, `q1_o` and `q2_o` read zero and `oe_o` is low. While `oe_ni` is low, `oe_o` is high and the outputs show the stored data. Toggling `oe_ni` changes no stored state.
- R9: Every address counter wraps from DEPTH-1 to zero. Lines of exactly DEPTH bytes therefore stay aligned with no reset after the first line.
- R10: While `rst_ni` is low, all counters are zero and both output registers are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_ni | input | 1 | Write enable, active low |
| wres_ni | input | 1 | Write address reset, active low, synchronous |
| wdata_i | input | WIDTH | Input pixel byte |
| re_ni | input | 1 | Read enable, active low |
| rres_ni | input | 1 | Read address reset, active low, synchronous |
| oe_ni | input | 1 | Output enable, active low |
| q1_o | output | WIDTH | One-line delayed pixel |
| q2_o | output | WIDTH | Two-line delayed pixel |
| oe_o | output | 1 | High when the data outputs are enabled |

## Verification
The bench builds the block with WIDTH 8 and DEPTH 32 rather than the default 5120. This puts counter wrap, and runs of several full lines, within a few hundred cycles. Lines of 24 bytes with random stalls and output-enable toggling cover the delayed outputs, hold behaviour and reset priority. Lines of exactly 32 bytes with no reset after the first line show that counter wrap alone keeps the one-line and two-line outputs aligned.

// File: rtl/lineq_pkg.sv
package lineq_pkg;
  // per-counter control decoded from active-low pins
  typedef struct packed {
    logic clr;
    logic en;
  } lq_ctl_t;

  localparam int unsigned LQ_NUM_RD_CTR = 2;
endpackage

// File: rtl/lineq_ctr.sv
module lineq_ctr
  import lineq_pkg::*;
#(
  parameter int unsigned DEPTH = 5120,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  lq_ctl_t       ctl_i,
  output logic [AW-1:0] cnt_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_o <= '0;
    else if (ctl_i.clr) cnt_o <= '0;
    else if (ctl_i.en)  cnt_o <= (cnt_o == LAST) ? '0 : cnt_o + 1'b1;
  end

  p_clr_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.clr |=> (cnt_o == '0));

  p_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.en && !ctl_i.clr && cnt_o == LAST) |=> (cnt_o == '0));

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_i.en && !ctl_i.clr) |=> $stable(cnt_o));

  p_in_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= LAST);
endmodule

// File: rtl/lineq_ram.sv
module lineq_ram #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 5120,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             wclk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // registered read; on a shared clock the old word wins
  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/line_delay_mem.sv
module line_delay_mem
  import lineq_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 5120,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             we_ni,
  input  logic             wres_ni,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             re_ni,
  input  logic             rres_ni,
  input  logic             oe_ni,
  output logic [WIDTH-1:0] q1_o,
  output logic [WIDTH-1:0] q2_o,
  output logic             oe_o
);
  lq_ctl_t          wctl, rctl;
  logic [AW-1:0]    waddr;
  logic [AW-1:0]    raddr [LQ_NUM_RD_CTR];
  logic [WIDTH-1:0] q1_q, q2_q;
  logic             pend_q;
  logic [AW-1:0]    paddr_q;

  // reset takes priority over enable on both sides
  assign wctl = '{clr: !wres_ni, en: !we_ni && wres_ni};
  assign rctl = '{clr: !rres_ni, en: !re_ni && rres_ni};

  lineq_ctr #(.DEPTH(DEPTH)) u_wctr (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .ctl_i (wctl),
    .cnt_o (waddr)
  );

  for (genvar g = 0; g < LQ_NUM_RD_CTR; g++) begin : g_rctr
    lineq_ctr #(.DEPTH(DEPTH)) u_rctr (
      .clk_i (rclk_i),
      .rst_ni(rst_ni),
      .ctl_i (rctl),
      .cnt_o (raddr[g])
    );
  end

  lineq_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_buf1 (
    .wclk_i (wclk_i),
    .we_i   (wctl.en),
    .waddr_i(waddr),
    .wdata_i(wdata_i),
    .rclk_i (rclk_i),
    .rst_ni (rst_ni),
    .re_i   (rctl.en),
    .raddr_i(raddr[0]),
    .rdata_o(q1_q)
  );

  // the byte just read from buf1 is committed one read cycle later at the
  // address it was read from; repeating the write while idle is harmless
  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      paddr_q <= '0;
    end else if (rctl.en) begin
      pend_q  <= 1'b1;
      paddr_q <= raddr[1];
    end
  end

  lineq_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_buf2 (
    .wclk_i (rclk_i),
    .we_i   (pend_q),
    .waddr_i(paddr_q),
    .wdata_i(q1_q),
    .rclk_i (rclk_i),
    .rst_ni (rst_ni),
    .re_i   (rctl.en),
    .raddr_i(raddr[1]),
    .rdata_o(q2_q)
  );

  assign oe_o = !oe_ni;
  assign q1_o = oe_o ? q1_q : '0;
  assign q2_o = oe_o ? q2_q : '0;

  p_rd_hold_r7: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (re_ni && rres_ni) |=> ($stable(q1_q) && $stable(q2_q)));

  p_rres_hold_r4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !rres_ni |=> ($stable(q1_q) && $stable(q2_q) && raddr[0] == '0));

  p_ctr_align_r6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    raddr[0] == raddr[1]);

  p_wr_hold_r2: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (we_ni && wres_ni) |=> $stable(waddr));
endmodule

// File: tb/line_delay_mem_bench.sv
module line_delay_mem_bench;
  localparam int W  = 8;
  localparam int D  = 32;
  localparam int L1 = 24;

  logic         wclk, rclk, rst_n;
  logic         we_n, wres_n, re_n, rres_n, oe_n;
  logic [W-1:0] wdata, q1, q2;
  logic         oe;

  int n_tot = 0, n_fail = 0;
  logic [W-1:0] hist [0:7][0:D-1];
  logic [W-1:0] e1, e2;
  bit           k1, k2;

  line_delay_mem #(.WIDTH(W), .DEPTH(D)) u_line_delay_mem (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .we_ni(we_n), .wres_ni(wres_n), .wdata_i(wdata),
    .re_ni(re_n), .rres_ni(rres_n), .oe_ni(oe_n),
    .q1_o(q1), .q2_o(q2), .oe_o(oe)
  );

  // 50 MHz; read edge leads the write edge by 5 ns
  initial begin rclk = 1'b0; forever #10 rclk = ~rclk; end
  initial begin wclk = 1'b0; #5; forever #10 wclk = ~wclk; end

  task automatic chk(input string req, input int act, input int exp);
    n_tot++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit rnd(input int unsigned m);
    return ($urandom % m) == 0;
  endfunction

  // one read/write cycle; expected outputs follow from the line history
  task automatic step(input bit wr, input bit rr, input bit w, input bit r,
                      input bit o, input logic [W-1:0] d, input int ln,
                      input int ps, input string t1, input string t2);
    wres_n = wr; rres_n = rr; we_n = w; re_n = r; oe_n = o; wdata = d;
    @(posedge wclk); #3;
    if (rr && !r) begin
      k1 = (ln >= 1); if (k1) e1 = hist[ln-1][ps];
      k2 = (ln >= 2); if (k2) e2 = hist[ln-2][ps];
    end
    chk("R8 oe_o", int'(oe), int'(!o));
    if (o) begin
      chk("R8 q1 gated", int'(q1), 0);
      chk("R8 q2 gated", int'(q2), 0);
    end else begin
      if (k1) chk(t1, int'(q1), int'(e1));
      if (k2) chk(t2, int'(q2), int'(e2));
    end
  endtask

  task automatic run_line(input int ln, input int len, input bit do_rst,
                          input string t1, input string t2);
    int pos = 0;
    if (do_rst)
      step(1'b0, 1'b0, rnd(2), rnd(2), rnd(6), W'($urandom), ln, 0,
           "R3 R4 q1", "R3 R4 q2");
    while (pos < len) begin
      if (rnd(5)) begin
        step(1'b1, 1'b1, 1'b1, 1'b1, rnd(6), W'($urandom), ln, pos,
             "R2 R7 q1", "R2 R7 q2");
      end else begin
        logic [W-1:0] d = W'($urandom);
        hist[ln][pos] = d;
        step(1'b1, 1'b1, 1'b0, 1'b0, rnd(6), d, ln, pos, t1, t2);
        pos++;
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; we_n = 1'b1; wres_n = 1'b1; re_n = 1'b1;
    rres_n = 1'b1; oe_n = 1'b0; wdata = '0;
    k1 = 1'b1; k2 = 1'b1; e1 = '0; e2 = '0;
    #53;
    chk("R10 q1 in reset", int'(q1), 0);
    chk("R10 q2 in reset", int'(q2), 0);
    rst_n = 1'b1;
    @(posedge wclk); #3;
    chk("R10 q1 after reset", int'(q1), 0);
    chk("R10 q2 after reset", int'(q2), 0);
    chk("R8 oe_o after reset", int'(oe), 1);

    // phase 1: short lines, reset at each line start
    for (int n = 0; n < 8; n++) run_line(n, L1, 1'b1, "R1 R5 q1", "R6 q2");

    // phase 2: full-depth lines, only the first one reset
    k1 = 1'b0; k2 = 1'b0;
    for (int n = 0; n < 5; n++) run_line(n, D, n == 0, "R9 q1", "R9 q2");

    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end

  initial begin
    #4_000_000;
    n_tot++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end
endmodule